// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Manager

This block sits between a hub's port-command logic and the external power switches of up to seven downstream ports. Single-cycle request pulses from the hub controller turn each port's power on or off. The block drives one active-low, push-pull power-enable output per port. Each active-low overcurrent input from a switch passes through a synchroniser and a glitch filter. An overcurrent that lasts long enough removes the port's power without any help from software. It also raises a flag that stays set until software acknowledges it.

Two static straps select the operating mode. With the gang strap set, all ports share one power state and one overcurrent state. With the bus-power strap set, only the lower ports can be used and the upper ports stay unpowered. Three indicator outputs show whether the hub is configured, whether any port is powered, and whether no port has been shut down. All three go high-impedance while the hub is in low-power suspend.

Top module: `dsport_pwr_mgr`

## Requirements
- R1: During and right after reset, every `pwr_en_n_o` bit is 1 (port unpowered), and every `oc_flag_o` and `oc_now_o` bit is 0.
- R2: In per-port mode, a `pwr_on_i[i]` pulse on an unpowered, unflagged, usable port drives `pwr_en_n_o[i]` to 0 after the sampling clock edge. A `pwr_off_i[i]` pulse drives it back to 1. When both pulses arrive in the same cycle, off wins.
- R3: An overcurrent input (`oc_n_i[i]` = 0) must be sampled low on FILT_CYCLES consecutive clocks to count. After SYNC_STAGES + FILT_CYCLES edges, counted from the first low sample, `oc_now_o[i]` goes to 1. A shorter low pulse never sets `oc_now_o` or `oc_flag_o`. `oc_now_o` clears SYNC_STAGES + 1 edges after the input returns high.
- R4: When a port is powered and its filtered overcurrent is active, the next edge sets `pwr_en_n_o[i]` = 1 and `oc_flag_o[i]` = 1.
- R5: While a port is flagged, `pwr_on_i` has no effect on it. `oc_ack_i[i]` clears the flag and leaves the port unpowered until a new `pwr_on_i[i]`.
- R6: In per-port mode, the commands and the overcurrent of one port never change another port's outputs.
- R7: With `ganged_i` = 1, a command bit on any usable port acts on all usable ports. A filtered overcurrent on any usable port trips all of them. All usable enables and flags are equal.
- R8: With `bus_pwr_i` = 1, ports with index BUS_PORTS and above stay unpowered with flag 0 and `oc_now_o` 0, and their requests and overcurrents are ignored.
- R9: When not suspended, `led_anypwr_o` is 1 when at least one port is powered and 0 otherwise.
- R10: When not suspended, `led_nodis_o` is 1 only when no usable port is flagged.
- R11: When not suspended, `led_cfg_o` follows `hub_cfg_i`.
- R12: While `suspend_i` = 1, all three indicator outputs are high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ganged_i | input | 1 | Static strap: 1 selects shared power control for all ports |
| bus_pwr_i | input | 1 | Static strap: 1 limits operation to BUS_PORTS ports |
| hub_cfg_i | input | 1 | Hub configured indication from the controller |
| suspend_i | input | 1 | Low-power suspend; floats the indicator outputs |
| pwr_on_i | input | NUM_PORTS | Per-port power-on request pulses |
| pwr_off_i | input | NUM_PORTS | Per-port power-off request pulses |
| oc_ack_i | input | NUM_PORTS | Per-port acknowledge that clears the overcurrent flag |
| oc_n_i | input | NUM_PORTS | Asynchronous active-low overcurrent inputs |
| pwr_en_n_o | output | NUM_PORTS | Active-low power-switch enables |
| oc_flag_o | output | NUM_PORTS | Latched overcurrent shutdown flags |
| oc_now_o | output | NUM_PORTS | Filtered present overcurrent status |
| led_cfg_o | output | 1 | Indicator: hub configured (tri-state) |
| led_anypwr_o | output | 1 | Indicator: any port powered (tri-state) |
| led_nodis_o | output | 1 | Indicator: no port shut down (tri-state) |

## Verification
Overcurrent pulses one clock shorter than the filter window are applied next to pulses held well past it. This separates a missing or short-counting filter from a correct one, and it pins the exact latency of `oc_now_o`. Request patterns include on and off pulses in the same cycle, a power-on request sent to a flagged port, and an acknowledge followed by a new request. These expose errors in priority and in the latching of the flag. The same stimulus is run in per-port, ganged, bus-powered and combined modes, so leakage between ports, a missing gang fan-out and unmasked upper ports each show up as a mismatch. Suspend is tested with the indicators in a state where each would drive 0, so a pulled-up float can be told apart from a driven value.

// File: rtl/dsport_pwr_pkg.sv
package dsport_pwr_pkg;

   typedef enum logic [1:0] {
      PS_OFF  = 2'd0,
      PS_ON   = 2'd1,
      PS_TRIP = 2'd2
   } port_st_e;

   // A port can be used unless bus-power limits the count below its index.
   function automatic logic port_usable(input int unsigned idx,
                                        input int unsigned bus_ports,
                                        input logic        bus_mode);
      return (!bus_mode) || (idx < bus_ports);
   endfunction

endpackage

// File: rtl/dsport_oc_filter.sv
module dsport_oc_filter #(
   parameter int unsigned FILT_CYCLES = 48000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_n_i,
   output logic oc_o
);
   localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
   localparam logic [CW-1:0] RUN_LAST = CW'(FILT_CYCLES - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   seen;

   // Synchronise and convert to active high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~oc_n_i};
   end

   assign seen = sync_q[SYNC_STAGES-1];

   // Accept an assertion only after an unbroken run of FILT_CYCLES samples.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         oc_o  <= 1'b0;
      end else if (!seen) begin
         run_q <= '0;
         oc_o  <= 1'b0;
      end else if (run_q == RUN_LAST) begin
         oc_o  <= 1'b1;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/dsport_port_fsm.sv
module dsport_port_fsm
   import dsport_pwr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     force_off_i,
   input  logic     on_i,
   input  logic     off_i,
   input  logic     ack_i,
   input  logic     oc_i,
   output port_st_e state_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= PS_OFF;
      end else if (force_off_i) begin
         state_o <= PS_OFF;
      end else begin
         unique case (state_o)
            PS_OFF:  if (on_i && !off_i) state_o <= PS_ON;
            PS_ON:   if (oc_i)           state_o <= PS_TRIP;
                     else if (off_i)     state_o <= PS_OFF;
            PS_TRIP: if (ack_i)          state_o <= PS_OFF;
            default:                     state_o <= PS_OFF;
         endcase
      end
   end
endmodule

// File: rtl/dsport_status.sv
module dsport_status #(
   parameter int unsigned NUM_PORTS = 7
) (
   input  logic [NUM_PORTS-1:0] on_vec_i,
   input  logic [NUM_PORTS-1:0] trip_vec_i,
   input  logic                 hub_cfg_i,
   input  logic                 suspend_i,
   output wire                  led_cfg_o,
   output wire                  led_anypwr_o,
   output wire                  led_nodis_o
);
   assign led_cfg_o    = suspend_i ? 1'bz : hub_cfg_i;
   assign led_anypwr_o = suspend_i ? 1'bz : (|on_vec_i);
   assign led_nodis_o  = suspend_i ? 1'bz : ~(|trip_vec_i);
endmodule

// File: rtl/dsport_pwr_mgr.sv
module dsport_pwr_mgr
   import dsport_pwr_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 7,
   parameter int unsigned BUS_PORTS   = 4,
   parameter int unsigned FILT_CYCLES = 48000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ganged_i,
   input  logic                 bus_pwr_i,
   input  logic                 hub_cfg_i,
   input  logic                 suspend_i,
   input  logic [NUM_PORTS-1:0] pwr_on_i,
   input  logic [NUM_PORTS-1:0] pwr_off_i,
   input  logic [NUM_PORTS-1:0] oc_ack_i,
   input  logic [NUM_PORTS-1:0] oc_n_i,
   output logic [NUM_PORTS-1:0] pwr_en_n_o,
   output logic [NUM_PORTS-1:0] oc_flag_o,
   output logic [NUM_PORTS-1:0] oc_now_o,
   output wire                  led_cfg_o,
   output wire                  led_anypwr_o,
   output wire                  led_nodis_o
);
   // Elaboration-time parameter checks.
   if (NUM_PORTS < 1)          begin : g_bad_np   $error("NUM_PORTS must be at least 1"); end
   if (BUS_PORTS > NUM_PORTS)  begin : g_bad_bp   $error("BUS_PORTS exceeds NUM_PORTS"); end
   if (FILT_CYCLES < 1)        begin : g_bad_filt $error("FILT_CYCLES must be at least 1"); end
   if (SYNC_STAGES < 2)        begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   logic [NUM_PORTS-1:0] usable;
   logic [NUM_PORTS-1:0] flt;
   logic [NUM_PORTS-1:0] on_vec;
   logic [NUM_PORTS-1:0] trip_vec;
   port_st_e             p_st [NUM_PORTS];
   port_st_e             g_st;
   logic                 g_on, g_off, g_ack, g_oc;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      assign usable[i] = port_usable(i, BUS_PORTS, bus_pwr_i);

      dsport_oc_filter #(
         .FILT_CYCLES (FILT_CYCLES),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .oc_n_i (oc_n_i[i]),
         .oc_o   (flt[i])
      );

      dsport_port_fsm u_fsm (
         .clk         (clk),
         .rst_n       (rst_n),
         .force_off_i (ganged_i | ~usable[i]),
         .on_i        (pwr_on_i[i]),
         .off_i       (pwr_off_i[i]),
         .ack_i       (oc_ack_i[i]),
         .oc_i        (flt[i]),
         .state_o     (p_st[i])
      );

      assign on_vec[i]   = usable[i] & (ganged_i ? (g_st == PS_ON)   : (p_st[i] == PS_ON));
      assign trip_vec[i] = usable[i] & (ganged_i ? (g_st == PS_TRIP) : (p_st[i] == PS_TRIP));
      assign oc_now_o[i] = usable[i] & (ganged_i ? g_oc : flt[i]);
   end

   // Shared controller for ganged operation: any usable port's input acts on all.
   assign g_on  = |(pwr_on_i  & usable);
   assign g_off = |(pwr_off_i & usable);
   assign g_ack = |(oc_ack_i  & usable);
   assign g_oc  = |(flt       & usable);

   dsport_port_fsm u_gang_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_off_i (~ganged_i),
      .on_i        (g_on),
      .off_i       (g_off),
      .ack_i       (g_ack),
      .oc_i        (g_oc),
      .state_o     (g_st)
   );

   assign pwr_en_n_o = ~on_vec;
   assign oc_flag_o  = trip_vec;

   dsport_status #(.NUM_PORTS(NUM_PORTS)) u_status (
      .on_vec_i     (on_vec),
      .trip_vec_i   (trip_vec),
      .hub_cfg_i    (hub_cfg_i),
      .suspend_i    (suspend_i),
      .led_cfg_o    (led_cfg_o),
      .led_anypwr_o (led_anypwr_o),
      .led_nodis_o  (led_nodis_o)
   );
endmodule

// File: rtl/dsport_pwr_mgr_chk.sv
module dsport_pwr_mgr_chk #(
   parameter int unsigned NUM_PORTS = 7,
   parameter int unsigned BUS_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ganged_i,
   input logic                 bus_pwr_i,
   input logic [NUM_PORTS-1:0] pwr_on_i,
   input logic [NUM_PORTS-1:0] oc_ack_i,
   input logic [NUM_PORTS-1:0] oc_n_i,
   input logic [NUM_PORTS-1:0] pwr_en_n_o,
   input logic [NUM_PORTS-1:0] oc_flag_o
);
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
      // R2: power never appears without a request
      a_r2_power_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pwr_en_n_o[i]) |-> $past(|pwr_on_i));

      // R3: a flag needs an overcurrent input seen low earlier
      a_r3_flag_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(oc_flag_o[i]) |-> ($past(oc_n_i, 3) != {NUM_PORTS{1'b1}}));

      // R4: shutdown happens only to a powered port
      a_r4_trip_from_powered: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(oc_flag_o[i]) |-> $past(!pwr_en_n_o[i]));

      // R5: the flag clears only through an acknowledge
      a_r5_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(oc_flag_o[i]) |-> $past(|oc_ack_i));

      if (i >= BUS_PORTS) begin : g_upper
         // R8: upper ports idle under bus power
         a_r8_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
            bus_pwr_i |-> (pwr_en_n_o[i] && !oc_flag_o[i]));
      end
   end

   // R7: ganged enables all agree when every port is usable
   a_r7_gang_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (ganged_i && !bus_pwr_i) |->
         ($countones(pwr_en_n_o) == 0 || $countones(pwr_en_n_o) == NUM_PORTS));
endmodule

bind dsport_pwr_mgr dsport_pwr_mgr_chk #(
   .NUM_PORTS (NUM_PORTS),
   .BUS_PORTS (BUS_PORTS)
) u_chk (.*);

// File: tb/dsport_pwr_mgr_tb_top.sv
module dsport_pwr_mgr_tb_top;
   localparam int NP = 7;
   localparam int BP = 4;
   localparam int FC = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          ganged = 1'b0, bus = 1'b0, cfg = 1'b0, susp = 1'b0;
   logic [NP-1:0] on = '0, off = '0, ack = '0, ocn = '1;
   logic [NP-1:0] en_n, flag, now;
   wire           l_cfg, l_any, l_nod;
   pullup (l_cfg);
   pullup (l_any);
   pullup (l_nod);

   dsport_pwr_mgr #(
      .NUM_PORTS (NP), .BUS_PORTS (BP), .FILT_CYCLES (FC), .SYNC_STAGES (2)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .ganged_i (ganged), .bus_pwr_i (bus),
      .hub_cfg_i (cfg), .suspend_i (susp), .pwr_on_i (on), .pwr_off_i (off),
      .oc_ack_i (ack), .oc_n_i (ocn), .pwr_en_n_o (en_n), .oc_flag_o (flag),
      .oc_now_o (now), .led_cfg_o (l_cfg), .led_anypwr_o (l_any), .led_nodis_o (l_nod)
   );

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // Behavioural reference: sample history, run lengths and port states.
   int ms1 [NP], ms2 [NP], run [NP], mflt [NP], mst [NP];
   int gst;

   function automatic bit use_p(int i);
      return !bus || (i < BP);
   endfunction

   function automatic logic [NP-1:0] umask();
      logic [NP-1:0] m;
      for (int i = 0; i < NP; i++) m[i] = use_p(i);
      return m;
   endfunction

   // 0 = off, 1 = powered, 2 = shut down by overcurrent
   function automatic int next_st(int st, bit r_on, bit r_off, bit r_ack, bit oc);
      if (st == 1) return oc ? 2 : (r_off ? 0 : 1);
      if (st == 2) return r_ack ? 0 : 2;
      return (r_on && !r_off) ? 1 : 0;
   endfunction

   function automatic bit gang_oc();
      bit g = 0;
      for (int i = 0; i < NP; i++) if (use_p(i) && mflt[i] != 0) g = 1;
      return g;
   endfunction

   always @(posedge clk) begin : m_upd
      bit gf;
      if (!rst_n) begin
         for (int i = 0; i < NP; i++) begin
            ms1[i] = 0; ms2[i] = 0; run[i] = 0; mflt[i] = 0; mst[i] = 0;
         end
         gst = 0;
      end else begin
         gf = gang_oc();
         if (ganged) gst = next_st(gst, |(on & umask()), |(off & umask()), |(ack & umask()), gf);
         else        gst = 0;
         for (int i = 0; i < NP; i++) begin
            if (ganged || !use_p(i)) mst[i] = 0;
            else mst[i] = next_st(mst[i], on[i], off[i], ack[i], mflt[i] != 0);
         end
         for (int i = 0; i < NP; i++) begin
            if (ms2[i] != 0) begin
               run[i] = run[i] + 1;
               mflt[i] = (run[i] >= FC) ? 1 : 0;
            end else begin
               run[i] = 0;
               mflt[i] = 0;
            end
            ms2[i] = ms1[i];
            ms1[i] = ocn[i] ? 0 : 1;
         end
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [NP-1:0] e_en, e_flag, e_now;
      bit any_on = 0, any_trip = 0, gf;
      gf = gang_oc();
      for (int i = 0; i < NP; i++) begin
         int st;
         st        = ganged ? gst : mst[i];
         e_en[i]   = !(use_p(i) && st == 1);
         e_flag[i] = use_p(i) && st == 2;
         e_now[i]  = use_p(i) && (ganged ? gf : (mflt[i] != 0));
         if (!e_en[i])  any_on = 1;
         if (e_flag[i]) any_trip = 1;
      end
      chk(cur_req, "pwr_en_n", 32'(en_n), 32'(e_en));
      chk(cur_req, "oc_flag",  32'(flag), 32'(e_flag));
      chk(cur_req, "oc_now",   32'(now),  32'(e_now));
      if (susp) begin
         // R12: floating outputs read the pull-up level
         chk("R12", "led_cfg",    32'(l_cfg), 32'd1);
         chk("R12", "led_anypwr", 32'(l_any), 32'd1);
         chk("R12", "led_nodis",  32'(l_nod), 32'd1);
      end else begin
         chk("R11", "led_cfg",    32'(l_cfg), 32'(cfg));
         chk("R9",  "led_anypwr", 32'(l_any), 32'(any_on));
         chk("R10", "led_nodis",  32'(l_nod), 32'(!any_trip));
      end
   endtask

   task automatic tick(int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         compare();
      end
   endtask

   task automatic do_reset(bit g, bit b);
      rst_n = 1'b0; ganged = g; bus = b;
      on = '0; off = '0; ack = '0; ocn = '1; susp = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic p_on(int p);
      on[p] = 1'b1; tick(1); on[p] = 1'b0;
   endtask

   task automatic p_off(int p);
      off[p] = 1'b1; tick(1); off[p] = 1'b0;
   endtask

   task automatic p_ack(int p);
      ack[p] = 1'b1; tick(1); ack[p] = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      cur_req = "R1";
      do_reset(0, 0);
      tick(1);

      cur_req = "R2";
      p_on(0); p_on(2); tick(1);
      on[0] = 1'b1; off[0] = 1'b1; tick(1); on[0] = 1'b0; off[0] = 1'b0;
      p_on(0); tick(1);
      cfg = 1'b1; tick(2);

      cur_req = "R3";
      ocn[2] = 1'b0; tick(FC - 1); ocn[2] = 1'b1; tick(6);

      cur_req = "R4";
      ocn[2] = 1'b0; tick(FC + 4);

      cur_req = "R5";
      p_on(2); ocn[2] = 1'b1; tick(4);
      p_on(2); p_ack(2); tick(1); p_on(2); tick(2);

      cur_req = "R6";
      p_on(1); ocn[1] = 1'b0; tick(FC + 4); ocn[1] = 1'b1; tick(4);
      p_off(0); p_off(2); cfg = 1'b0; tick(1);

      cur_req = "R12";
      susp = 1'b1; tick(3); susp = 1'b0; tick(1);

      cur_req = "R7";
      do_reset(1, 0);
      p_on(3); tick(2);
      ocn[5] = 1'b0; tick(FC + 4); ocn[5] = 1'b1;
      p_on(4); tick(4);
      p_ack(1); tick(1); p_on(6); tick(1); p_off(0); tick(1);

      cur_req = "R8";
      do_reset(0, 1);
      on = '1; tick(1); on = '0; tick(2);
      ocn[6] = 1'b0; tick(FC + 4); ocn[6] = 1'b1;
      ocn[1] = 1'b0; tick(FC + 4); ocn[1] = 1'b1; tick(4);
      do_reset(1, 1);
      p_on(6); tick(1); p_on(2); tick(1);
      ocn[5] = 1'b0; tick(FC + 4); ocn[5] = 1'b1;
      ocn[3] = 1'b0; tick(FC + 4); ocn[3] = 1'b1; tick(4);

      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL all watchdog: actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule